// File: doc/BRIEF.md
# Receive Interrupt and Idle Timeout Controller

This block produces the receive-side interrupt of one serial channel that buffers incoming characters in a 64-entry FIFO. It compares the FIFO fill level with a programmed threshold to raise a data-ready request. It also runs an idle timer that raises a timeout request when characters sit in the FIFO and nothing happens for four character times. One enable bit gates both requests. When both are present, an identification code names the timeout first.

The idle timer counts strobes of the 16x baud clock. It restarts whenever the deserializer marks the middle of a received stop bit, whenever software reads the holding register, and whenever the FIFO is empty. The character time follows the configured frame: one start bit, five to eight data bits, an optional parity bit and one or two stop bits.

Top module: `rx_irq_unit`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, clears the idle counter and both request flags. In the cycle after that edge `irq` is 0 and `irq_id` is 2'b00.
- R2: `rdy_irq` is registered. It is 1 in the cycle after an edge at which `fill_level` was at least the threshold, and 0 in the cycle after an edge at which `fill_level` was below it. The threshold is `trig_level`, except that a `trig_level` of 0 is treated as 1.
- R3: `tmo_irq` is 0 in the cycle after any edge at which `fill_level` was 0, however many strobes have arrived.
- R4: A `stop_mid` pulse restarts the idle count and clears the timeout flag.
- R5: A `rhr_rd` pulse restarts the idle count and clears the timeout flag.
- R6: With data in the FIFO and no restart, the timeout flag sets at the edge of the L-th `tick16` strobe after a restart. L = 64 × bits per frame, and bits per frame = 1 + (5 + `data_len`) + `par_en` + (1 + `two_stop`). `data_len` encodes 2'b00 = 5 bits up to 2'b11 = 8 bits.
- R7: The idle counter advances only at edges where `tick16` is 1. After the flag sets, the counter holds at its limit and the flag stays set until a restart.
- R8: `rx_irq_en` gates both requests. With it at 0, `rdy_irq`, `tmo_irq` and `irq` are 0 and `irq_id` is 2'b00. `irq` is the OR of the two gated requests.
- R9: `irq_id` is 2'b10 when `tmo_irq` is 1, otherwise 2'b01 when `rdy_irq` is 1, otherwise 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | 16x baud enable strobe |
| fill_level | input | 7 | Current number of characters in the receive FIFO (0 to 64) |
| trig_level | input | 7 | Programmed data-ready threshold |
| stop_mid | input | 1 | Pulse at the middle of each received stop bit |
| rhr_rd | input | 1 | Pulse for each read of the receive holding register |
| data_len | input | 2 | Data bits per character minus 5 |
| par_en | input | 1 | Parity bit present in the frame |
| two_stop | input | 1 | Frame carries two stop bits |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rdy_irq | output | 1 | Gated data-ready request |
| tmo_irq | output | 1 | Gated receive timeout request |
| irq | output | 1 | Combined receive interrupt |
| irq_id | output | 2 | Identification code of the pending source |

## Verification
The hardest case to reach is the exact edge where the timeout sets. Getting there takes hundreds of uninterrupted strobes, and the number depends on the frame configuration. The bench sweeps all sixteen frame settings and computes the limit arithmetically for each one. It holds the strobe high for exactly one strobe fewer than the limit, then one more. It also repeats the count after a restart placed just before expiry, and runs once with sparse strobes to show that only strobes advance the count. The threshold comparison is swept over every pair of fill level and threshold from 0 to 64.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

    typedef enum logic [1:0] {
        ID_NONE = 2'b00,
        ID_RDY  = 2'b01,
        ID_TMO  = 2'b10
    } irq_id_e;

    // Start bit + data bits + optional parity + one or two stop bits.
    function automatic logic [3:0] frame_bits(input logic [1:0] data_len,
                                              input logic       par_en,
                                              input logic       two_stop);
        return 4'd7 + {2'b00, data_len} + {3'b000, par_en} + {3'b000, two_stop};
    endfunction

endpackage

// File: rtl/rx_fill_cmp.sv
module rx_fill_cmp #(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [LVL_W-1:0] trig_level,
    output logic             above_q
);
    typedef struct packed {
        logic above;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic [LVL_W-1:0] eff_trig;

    always_comb begin
        // A zero threshold would fire on an empty FIFO; treat it as one.
        eff_trig = (trig_level == '0) ? LVL_W'(1) : trig_level;
        st_d = st_q;
        st_d.above = (fill_level >= eff_trig);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign above_q = st_q.above;
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import rx_irq_pkg::*;
#(
    parameter int LVL_W         = 7,
    parameter int TICKS_PER_BIT = 16,
    parameter int CHARS_TMO     = 4,
    parameter int MAX_FRAME     = 12,
    localparam int CNT_W        = $clog2(MAX_FRAME * TICKS_PER_BIT * CHARS_TMO + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick16,
    input  logic             stop_mid,
    input  logic             rhr_rd,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [1:0]       data_len,
    input  logic             par_en,
    input  logic             two_stop,
    output logic             expired_q
);
    localparam logic [CNT_W-1:0] TICKS_PER_FRAME_BIT = CNT_W'(TICKS_PER_BIT * CHARS_TMO);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             expired;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             restart;

    always_comb begin
        limit   = CNT_W'(frame_bits(data_len, par_en, two_stop)) * TICKS_PER_FRAME_BIT;
        restart = stop_mid | rhr_rd | (fill_level == '0);
        st_d    = st_q;
        if (restart) begin
            st_d.cnt     = '0;
            st_d.expired = 1'b0;
        end else begin
            if (tick16 && (st_q.cnt < limit)) st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.expired = (st_d.cnt >= limit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign expired_q = st_q.expired;
endmodule

// File: rtl/rx_irq_id.sv
module rx_irq_id
    import rx_irq_pkg::*;
(
    input  logic       above,
    input  logic       expired,
    input  logic       enable,
    output logic       rdy_irq,
    output logic       tmo_irq,
    output logic       irq,
    output logic [1:0] irq_id
);
    irq_id_e id_d;

    always_comb begin
        rdy_irq = enable & above;
        tmo_irq = enable & expired;
        irq     = rdy_irq | tmo_irq;
        // Both sources share one level; the timeout is named first.
        if (tmo_irq)      id_d = ID_TMO;
        else if (rdy_irq) id_d = ID_RDY;
        else              id_d = ID_NONE;
        irq_id = id_d;
    end
endmodule

// File: rtl/rx_irq_unit.sv
module rx_irq_unit #(
    parameter int FIFO_DEPTH    = 64,
    parameter int TICKS_PER_BIT = 16,
    parameter int CHARS_TMO     = 4,
    localparam int LVL_W        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick16,
    input  logic [LVL_W-1:0] fill_level,
    input  logic [LVL_W-1:0] trig_level,
    input  logic             stop_mid,
    input  logic             rhr_rd,
    input  logic [1:0]       data_len,
    input  logic             par_en,
    input  logic             two_stop,
    input  logic             rx_irq_en,
    output logic             rdy_irq,
    output logic             tmo_irq,
    output logic             irq,
    output logic [1:0]       irq_id
);
    logic above_q;
    logic expired_q;

    rx_fill_cmp #(.LVL_W(LVL_W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .fill_level (fill_level),
        .trig_level (trig_level),
        .above_q    (above_q)
    );

    rx_idle_timer #(
        .LVL_W         (LVL_W),
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .CHARS_TMO     (CHARS_TMO)
    ) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .tick16     (tick16),
        .stop_mid   (stop_mid),
        .rhr_rd     (rhr_rd),
        .fill_level (fill_level),
        .data_len   (data_len),
        .par_en     (par_en),
        .two_stop   (two_stop),
        .expired_q  (expired_q)
    );

    rx_irq_id u_id (
        .above   (above_q),
        .expired (expired_q),
        .enable  (rx_irq_en),
        .rdy_irq (rdy_irq),
        .tmo_irq (tmo_irq),
        .irq     (irq),
        .irq_id  (irq_id)
    );
endmodule

// File: rtl/rx_irq_unit_chk.sv
module rx_irq_unit_chk #(
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             tick16,
    input logic [LVL_W-1:0] fill_level,
    input logic             stop_mid,
    input logic             rhr_rd,
    input logic             rx_irq_en,
    input logic             rdy_irq,
    input logic             tmo_irq,
    input logic             irq,
    input logic [1:0]       irq_id
);
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq);

    a_r3_no_tmo_empty: assert property (@(posedge clk) disable iff (rst)
        (fill_level == '0) |=> !tmo_irq);

    a_r4_stop_restart: assert property (@(posedge clk) disable iff (rst)
        stop_mid |=> !tmo_irq);

    a_r5_read_restart: assert property (@(posedge clk) disable iff (rst)
        rhr_rd |=> !tmo_irq);

    a_r7_tick_only: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_irq) && $stable(rx_irq_en) |-> $past(tick16));

    a_r8_gate: assert property (@(posedge clk) disable iff (rst)
        !rx_irq_en |-> !irq && (irq_id == 2'b00));

    a_r9_tmo_first: assert property (@(posedge clk) disable iff (rst)
        tmo_irq |-> (irq_id == 2'b10));

    a_r9_rdy_code: assert property (@(posedge clk) disable iff (rst)
        rdy_irq && !tmo_irq |-> (irq_id == 2'b01));
endmodule

bind rx_irq_unit rx_irq_unit_chk #(.LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick16     (tick16),
    .fill_level (fill_level),
    .stop_mid   (stop_mid),
    .rhr_rd     (rhr_rd),
    .rx_irq_en  (rx_irq_en),
    .rdy_irq    (rdy_irq),
    .tmo_irq    (tmo_irq),
    .irq        (irq),
    .irq_id     (irq_id)
);

// File: tb/rx_irq_unit_tb.sv
module rx_irq_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst, tick16, stop_mid, rhr_rd, par_en, two_stop, rx_irq_en;
    logic [6:0] fill_level, trig_level;
    logic [1:0] data_len;
    logic       rdy_irq, tmo_irq, irq;
    logic [1:0] irq_id;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_irq_unit u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .fill_level(fill_level),
        .trig_level(trig_level), .stop_mid(stop_mid), .rhr_rd(rhr_rd),
        .data_len(data_len), .par_en(par_en), .two_stop(two_stop),
        .rx_irq_en(rx_irq_en), .rdy_irq(rdy_irq), .tmo_irq(tmo_irq),
        .irq(irq), .irq_id(irq_id)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance one edge and sample 1 time unit later; inputs change here too.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic int lim(input int dl, input int p, input int s);
        return 64 * (1 + 5 + dl + p + 1 + s);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int l;
        rst = 1'b1; tick16 = 0; stop_mid = 0; rhr_rd = 0;
        fill_level = 7'd10; trig_level = 7'd1; rx_irq_en = 1'b1;
        data_len = 2'd0; par_en = 0; two_stop = 0;
        repeat (3) cyc();
        // R1: flags cleared by reset although inputs would set data-ready
        check("R1 irq", irq, 0);
        check("R1 irq_id", irq_id, 0);
        rst = 1'b0;

        // R2/R9: exhaustive fill vs threshold, no strobes so no timeout
        for (int t = 0; t <= 64; t++) begin
            for (int f = 0; f <= 64; f++) begin
                int e;
                trig_level = 7'(t); fill_level = 7'(f);
                cyc();
                e = (f >= ((t == 0) ? 1 : t)) ? 1 : 0;
                check("R2 rdy_irq", rdy_irq, e);
                check("R9 irq_id rdy", irq_id, e);
                check("R8 irq or", irq, e);
            end
        end

        // R4..R9 for every frame configuration
        for (int c = 0; c < 16; c++) begin
            data_len = 2'(c & 3); par_en = c[2]; two_stop = c[3];
            l = lim(c & 3, (c >> 2) & 1, (c >> 3) & 1);
            fill_level = 7'd5; trig_level = 7'd64; tick16 = 0;
            rhr_rd = 1; cyc(); rhr_rd = 0;
            check("R5 tmo after read", tmo_irq, 0);
            tick16 = 1;
            repeat (l - 1) cyc();
            check("R6 tmo one strobe early", tmo_irq, 0);
            cyc();
            check("R6 tmo at limit", tmo_irq, 1);
            check("R9 id tmo", irq_id, 2);
            repeat (20) cyc();
            check("R7 tmo held", tmo_irq, 1);
            rx_irq_en = 0; #1;
            check("R8 gated irq", irq, 0);
            check("R8 gated id", irq_id, 0);
            rx_irq_en = 1; trig_level = 7'd1;
            cyc();
            check("R9 both rdy", rdy_irq, 1);
            check("R9 both id", irq_id, 2);
            rhr_rd = 1; cyc(); rhr_rd = 0;
            check("R5 tmo cleared by read", tmo_irq, 0);
            check("R9 id after read", irq_id, 1);
            repeat (l - 10) cyc();
            stop_mid = 1; cyc(); stop_mid = 0;
            check("R4 tmo after stop", tmo_irq, 0);
            repeat (l - 1) cyc();
            check("R4 restart early", tmo_irq, 0);
            cyc();
            check("R4 restart at limit", tmo_irq, 1);
            trig_level = 7'd64;
        end

        // R3: empty FIFO clears and blocks the timeout
        fill_level = 7'd0;
        cyc();
        check("R3 empty clears", tmo_irq, 0);
        repeat (2000) cyc();
        check("R3 empty long", tmo_irq, 0);

        // R7: no strobe, no progress; then sparse strobes
        fill_level = 7'd3; tick16 = 0;
        repeat (1000) cyc();
        check("R7 no strobe", tmo_irq, 0);
        for (int i = 0; i < l; i++) begin
            if (i == l - 1) check("R7 sparse early", tmo_irq, 0);
            tick16 = 1; cyc(); tick16 = 0; cyc(); cyc();
        end
        check("R7 sparse limit", tmo_irq, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule